// File: doc/BRIEF.md
# External Interrupt Pin Controller

The block takes up to eight asynchronous external interrupt pins and drives one interrupt request output for each pin. Every pin goes through a two-flop synchroniser. A per-pin detector then watches for the configured event: a rising edge, a falling edge, both edges, a high level or a low level. A detected event sets a sticky pending bit. The pin's request output is high while that bit is set, the pin is unmasked and its priority field is non-zero.

Software reaches five registers through a simple synchronous bus with an address, a write enable, write data and combinational read data:

- a sense register holding the detection mode fields;
- a priority register with a 4-bit field per pin;
- a source register that shows the pending bits and clears them when written with zeros;
- two write-only registers, one that sets mask bits and one that clears them.

Pin 0 always uses the most significant field or bit of each register. The block does no arbitration between pins and no vectoring.

Top module: `extirq_ctrl`

## Requirements
- R1: Each pin n (0 to NUM_PINS-1) drives only its own output irq_o[n]. An event on one pin never raises another pin's output.
- R2: Sense code 1 detects a rising edge and code 0 a falling edge on the synchronised pin. The pending bit is set in the second cycle after the synchronised change, and only on the selected edge.
- R3: A pending bit set by an edge stays set after the pin returns to its idle level, until software clears it.
- R4: Sense code 3 (high level) and code 2 (low level) set the pending bit on every cycle the level is active, so a clear written while the level is active has no lasting effect.
- R5: Sense code 4 detects both edges. Codes 5 to 15 detect nothing.
- R6: Address 2 (source) reads the pending bit of pin n at bit SRC_W-1-n. A write to it clears each pending bit written as 0 and keeps each bit written as 1.
- R7: A write to address 3 (mask set) masks every pin whose bit SRC_W-1-n is 1. Bits written as 0 have no effect. Masking hides the output but keeps the pending bit.
- R8: A write to address 4 (mask clear) unmasks every pin whose bit SRC_W-1-n is 1. Bits written as 0 have no effect.
- R9: Address 1 (priority) holds a 4-bit field for pin n at bits (7-n)*4+3 down to (7-n)*4. A zero field silences the pin's output and any non-zero field lets it through. The register reads back as written.
- R10: Address 0 (sense) holds the mode field of pin n at bits starting at (7-n)*SENSE_W, SENSE_W bits wide. The register reads back as written.
- R11: After reset every pin is masked, all pending bits are clear, the sense and priority registers read 0, and all outputs are low.
- R12: irq_o[n] is high exactly when pin n is pending, unmasked and has a non-zero priority field. The mask registers read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | NUM_PINS | Asynchronous external interrupt pins |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_o | output | NUM_PINS | Per-pin interrupt request outputs |

## Verification
The bound checker watches the following on every cycle:

- a pending bit never drops without a source write;
- a mask-set write silences the addressed output on the next cycle;
- a mask-clear write unmasks the pin;
- a zero priority write silences the pin;
- an output is high only for a pending, unmasked pin;
- reset leaves all outputs low and all pins masked.

Only the bench scenarios can show the rest. This covers the detection of each sense mode, including the level reassertion after a clear and the dead codes. It also covers the bit-reversed placement of pins in the register fields, and the contents read back through the source register.

// File: rtl/extirq_pkg.sv
// Shared constants for the external interrupt pin controller.
// Assumes a 3-bit register address and 32-bit data bus.
package extirq_pkg;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 3;
    localparam int PRIO_W = 4;
    localparam int FIELDS = 8;

    localparam logic [ADDR_W-1:0] A_SENSE   = 3'd0;
    localparam logic [ADDR_W-1:0] A_PRIO    = 3'd1;
    localparam logic [ADDR_W-1:0] A_SOURCE  = 3'd2;
    localparam logic [ADDR_W-1:0] A_MASKSET = 3'd3;
    localparam logic [ADDR_W-1:0] A_MASKCLR = 3'd4;

    typedef enum logic [3:0] {
        SN_FALL  = 4'd0,
        SN_RISE  = 4'd1,
        SN_LOW   = 4'd2,
        SN_HIGH  = 4'd3,
        SN_BOTH  = 4'd4
    } sense_e;
endpackage

// File: rtl/extirq_sync.sv
// Two-flop synchroniser for a vector of asynchronous pins.
// Assumes each bit is independent; no bus coherency is given.
module extirq_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Two capture stages; reset to the idle-low state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/extirq_detect.sv
// Per-pin event detector: compares the synchronised level with the
// previous sample and reports a hit according to the sense code.
// Assumes level_i is already synchronous to clk.
module extirq_detect
    import extirq_pkg::*;
#(
    parameter int SENSE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               level_i,
    input  logic [SENSE_W-1:0] mode_i,
    output logic               hit_o
);
    logic       prev_q;
    logic [3:0] code;
    logic       rise;
    logic       fall;

    // Remember the last synchronised sample.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level_i;
    end

    assign code = 4'(mode_i);
    assign rise = level_i & ~prev_q;
    assign fall = ~level_i & prev_q;

    // Decode the sense code into a hit; unknown codes never hit.
    always_comb begin
        case (code)
            SN_FALL: hit_o = fall;
            SN_RISE: hit_o = rise;
            SN_LOW:  hit_o = ~level_i;
            SN_HIGH: hit_o = level_i;
            SN_BOTH: hit_o = rise | fall;
            default: hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/extirq_regfile.sv
// Register file: sense, priority, pending and mask state with the bus
// decode. Pin n uses the field or bit counted from the top of each
// register. Assumes NUM_PINS <= 8 and SRC_W is 8 or 32.
module extirq_regfile
    import extirq_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int SENSE_W  = 4,
    parameter int SRC_W    = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic                          bus_wr,
    input  logic [BUS_W-1:0]              bus_wdata,
    output logic [BUS_W-1:0]              bus_rdata,
    input  logic [NUM_PINS-1:0]           hit_i,
    output logic [NUM_PINS*SENSE_W-1:0]   mode_o,
    output logic [NUM_PINS-1:0]           pend_o,
    output logic [NUM_PINS-1:0]           mask_o,
    output logic [NUM_PINS-1:0]           prio_on_o
);
    logic [BUS_W-1:0]    sense_q;
    logic [BUS_W-1:0]    prio_q;
    logic [NUM_PINS-1:0] pend_q;
    logic [NUM_PINS-1:0] pend_d;
    logic [NUM_PINS-1:0] mask_q;
    logic [NUM_PINS-1:0] mask_d;
    logic [SRC_W-1:0]    src_view;

    logic wr_sense, wr_prio, wr_src, wr_mset, wr_mclr;
    assign wr_sense = bus_wr && (bus_addr == A_SENSE);
    assign wr_prio  = bus_wr && (bus_addr == A_PRIO);
    assign wr_src   = bus_wr && (bus_addr == A_SOURCE);
    assign wr_mset  = bus_wr && (bus_addr == A_MASKSET);
    assign wr_mclr  = bus_wr && (bus_addr == A_MASKCLR);

    // Configuration registers, full-width and read back as written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sense_q <= '0;
            prio_q  <= '0;
        end else begin
            if (wr_sense) sense_q <= bus_wdata;
            if (wr_prio)  prio_q  <= bus_wdata;
        end
    end

    // Next pending and mask state per pin; a new hit wins over a clear.
    always_comb begin
        for (int n = 0; n < NUM_PINS; n++) begin
            pend_d[n] = hit_i[n] |
                        (pend_q[n] & ~(wr_src & ~bus_wdata[SRC_W-1-n]));
            mask_d[n] = mask_q[n];
            if (wr_mset && bus_wdata[SRC_W-1-n]) mask_d[n] = 1'b1;
            if (wr_mclr && bus_wdata[SRC_W-1-n]) mask_d[n] = 1'b0;
        end
    end

    // Pending and mask storage; reset leaves everything masked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            mask_q <= '1;
        end else begin
            pend_q <= pend_d;
            mask_q <= mask_d;
        end
    end

    // Field extraction per pin, counted from the top of the register.
    for (genvar n = 0; n < NUM_PINS; n++) begin : g_field
        assign mode_o[n*SENSE_W +: SENSE_W] = sense_q[(FIELDS-1-n)*SENSE_W +: SENSE_W];
        assign prio_on_o[n] = |prio_q[(FIELDS-1-n)*PRIO_W +: PRIO_W];
    end

    // Pending bits placed with pin 0 at the top of the source register.
    always_comb begin
        src_view = '0;
        for (int n = 0; n < NUM_PINS; n++) src_view[SRC_W-1-n] = pend_q[n];
    end

    // Read decode; the mask registers are write-only and read as zero.
    always_comb begin
        case (bus_addr)
            A_SENSE:  bus_rdata = sense_q;
            A_PRIO:   bus_rdata = prio_q;
            A_SOURCE: bus_rdata = BUS_W'(src_view);
            default:  bus_rdata = '0;
        endcase
    end

    assign pend_o = pend_q;
    assign mask_o = mask_q;
endmodule

// File: rtl/extirq_ctrl.sv
// Top: external interrupt pin controller. Synchronises the pins,
// detects events per pin, and gates the pending state into one
// request output per pin. Assumes 1 <= NUM_PINS <= 8.
module extirq_ctrl
    import extirq_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int SENSE_W  = 4,
    parameter int SRC_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic [2:0]          bus_addr,
    input  logic                bus_wr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic [NUM_PINS-1:0] irq_o
);
    logic [NUM_PINS-1:0]         pin_sync;
    logic [NUM_PINS-1:0]         hit;
    logic [NUM_PINS*SENSE_W-1:0] mode;
    logic [NUM_PINS-1:0]         pend_q;
    logic [NUM_PINS-1:0]         mask_q;
    logic [NUM_PINS-1:0]         prio_on;

    extirq_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (pin_sync)
    );

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
        extirq_detect #(.SENSE_W(SENSE_W)) u_det (
            .clk     (clk),
            .rst_n   (rst_n),
            .level_i (pin_sync[n]),
            .mode_i  (mode[n*SENSE_W +: SENSE_W]),
            .hit_o   (hit[n])
        );
    end

    extirq_regfile #(
        .NUM_PINS (NUM_PINS),
        .SENSE_W  (SENSE_W),
        .SRC_W    (SRC_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .hit_i     (hit),
        .mode_o    (mode),
        .pend_o    (pend_q),
        .mask_o    (mask_q),
        .prio_on_o (prio_on)
    );

    // Request output: pending, unmasked and with a live priority.
    assign irq_o = pend_q & ~mask_q & prio_on;
endmodule

// File: rtl/extirq_ctrl_checks.sv
// Checker bound to extirq_ctrl: per-pin temporal properties on the
// bus, the outputs and the pending and mask state.
module extirq_ctrl_checks #(
    parameter int NUM_PINS = 8,
    parameter int SRC_W    = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [2:0]          bus_addr,
    input logic                bus_wr,
    input logic [31:0]         bus_wdata,
    input logic [NUM_PINS-1:0] irq_o,
    input logic [NUM_PINS-1:0] pend_q,
    input logic [NUM_PINS-1:0] mask_q
);
    // R11: reset leaves outputs low and all pins masked.
    a_r11_reset_state: assert property (@(posedge clk)
        !rst_n |=> (irq_o == '0 && mask_q == '1));

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_chk
        // R3: a pending bit only drops on a source write.
        a_r3_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_q[n] && !(bus_wr && bus_addr == 3'd2)) |=> pend_q[n]);
        // R7: a mask-set write silences the pin next cycle.
        a_r7_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == 3'd3 && bus_wdata[SRC_W-1-n]) |=> !irq_o[n]);
        // R8: a mask-clear write unmasks the pin.
        a_r8_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == 3'd4 && bus_wdata[SRC_W-1-n]) |=> !mask_q[n]);
        // R9: a zero priority field silences the pin.
        a_r9_prio_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == 3'd1 && bus_wdata[(7-n)*4 +: 4] == 4'd0) |=> !irq_o[n]);
        // R12: an output needs a pending, unmasked pin.
        a_r12_out_gate: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[n] |-> (pend_q[n] && !mask_q[n]));
    end
endmodule

bind extirq_ctrl extirq_ctrl_checks #(.NUM_PINS(NUM_PINS), .SRC_W(SRC_W)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .irq_o     (irq_o),
    .pend_q    (pend_q),
    .mask_q    (mask_q)
);

// File: tb/extirq_ctrl_test.sv
// Directed bench for extirq_ctrl; one task per scenario.
module extirq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pin_i = '0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  irq_o;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    extirq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic settle(int c);
        repeat (c) @(negedge clk);
    endtask

    task automatic quiet();
        wr(3'd0, 32'h7777_7777);
        settle(4);
        wr(3'd2, 32'h0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R11 irq", 32'(irq_o), 32'h0);
        rd(3'd0, d); chk("R11 sense", d, 32'h0);
        rd(3'd1, d); chk("R11 prio", d, 32'h0);
        rd(3'd2, d); chk("R11 source", d, 32'h0);
        rd(3'd3, d); chk("R12 mask reads zero", d, 32'h0);
        // Raise a pin with default falling sense then lower it: pending but masked.
        pin_i[6] = 1'b1; settle(4); pin_i[6] = 1'b0; settle(4);
        chk("R11 masked after reset", 32'(irq_o), 32'h0);
        wr(3'd1, 32'hFFFF_FFFF);
        wr(3'd4, 32'hFF);
        chk("R8 unmask shows pending pin6", 32'(irq_o), 32'h40);
        wr(3'd2, 32'h0);
        chk("R6 clear all", 32'(irq_o), 32'h0);
    endtask

    task automatic t_edges();
        logic [31:0] d;
        wr(3'd0, 32'h1077_7777);
        rd(3'd0, d); chk("R10 sense readback", d, 32'h1077_7777);
        pin_i[0] = 1'b1; pin_i[1] = 1'b1; pin_i[7] = 1'b1;
        settle(4);
        chk("R2 rise only pin0", 32'(irq_o), 32'h01);
        pin_i[0] = 1'b0; pin_i[1] = 1'b0; pin_i[7] = 1'b0;
        settle(4);
        chk("R3 R1 pin0 sticky, pin1 fell, pin7 dead (R5)", 32'(irq_o), 32'h03);
        rd(3'd2, d); chk("R6 source bit order", d, 32'hC0);
        wr(3'd2, 32'h7F);
        rd(3'd2, d); chk("R6 selective clear", d, 32'h40);
        quiet();
    endtask

    task automatic t_both();
        wr(3'd0, 32'h7747_7777);
        pin_i[2] = 1'b1; settle(4);
        chk("R5 both rise", 32'(irq_o), 32'h04);
        wr(3'd2, 32'h0);
        chk("R5 cleared", 32'(irq_o), 32'h0);
        pin_i[2] = 1'b0; settle(4);
        chk("R5 both fall", 32'(irq_o), 32'h04);
        quiet();
    endtask

    task automatic t_level();
        logic [31:0] d;
        pin_i[3] = 1'b1; pin_i[4] = 1'b1; settle(4);
        wr(3'd0, 32'h7773_2777);
        settle(2);
        wr(3'd2, 32'h0);
        chk("R4 high level reasserts, low idle", 32'(irq_o), 32'h08);
        rd(3'd2, d); chk("R4 source pin3", d, 32'h10);
        pin_i[3] = 1'b0; settle(4);
        wr(3'd2, 32'h0);
        chk("R4 level gone", 32'(irq_o), 32'h0);
        pin_i[4] = 1'b0; settle(4);
        chk("R4 low level", 32'(irq_o), 32'h10);
        pin_i[4] = 1'b1; settle(4);
        quiet();
    endtask

    task automatic t_mask_prio();
        logic [31:0] d;
        wr(3'd0, 32'h7777_7177);
        pin_i[5] = 1'b1; settle(4);
        chk("R2 pin5 rise", 32'(irq_o), 32'h20);
        wr(3'd3, 32'h04);
        chk("R7 masked", 32'(irq_o), 32'h0);
        rd(3'd2, d); chk("R7 pending kept", d, 32'h04);
        wr(3'd4, 32'h00);
        chk("R8 zero bits ignored", 32'(irq_o), 32'h0);
        wr(3'd4, 32'h04);
        chk("R8 unmasked", 32'(irq_o), 32'h20);
        wr(3'd3, 32'h00);
        chk("R7 zero bits ignored", 32'(irq_o), 32'h20);
        wr(3'd1, 32'hFFFF_F0FF);
        chk("R9 zero prio silences", 32'(irq_o), 32'h0);
        rd(3'd1, d); chk("R9 prio readback", d, 32'hFFFF_F0FF);
        wr(3'd1, 32'h0000_0100);
        chk("R12 nonzero prio passes", 32'(irq_o), 32'h20);
        pin_i[5] = 1'b0;
        quiet();
    endtask

    initial begin
        settle(3);
        rst_n = 1'b1;
        settle(1);
        t_reset();
        t_edges();
        t_both();
        t_level();
        t_mask_prio();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule